// File: doc/BRIEF.md
# Cascadable Up/Down Presettable Counter

This block is a synchronous binary counter of parameterized width (8 bits by default). It counts up or down and can be preset from a parallel bus. The active-low clear acts on the count at once, without waiting for a clock edge. Two active-high enables must both be high for the count to step. The second enable, the chain enable, also gates a combinational terminal-count flag. That flag rises at the end of the range in the selected direction, so one stage can drive the enables of the next stage.

The inputs are resolved in a fixed order. Clear comes first, then load, then counting, and hold is the default. Counting is cyclic natural binary over 0 to 2^WIDTH-1.

Top module: `updn_counter`

## Requirements
- R1: When `clr_n` goes low, `count` becomes 0 immediately, without any clock edge.
- R2: While `clr_n` is low, `count` stays 0 across rising clock edges, whatever `load`, `cnt_en`, `chain_en`, `up` and `preset` are.
- R3: With `clr_n` high and `load` high, `count` takes the value of `preset` on the rising edge. This holds even when both enables are high, because load has priority over counting.
- R4: With `clr_n` high, `load` low, both enables high and `up`=1, `count` increases by one on each rising edge.
- R5: With `clr_n` high, `load` low, both enables high and `up`=0, `count` decreases by one on each rising edge.
- R6: With `load` low and either `cnt_en` or `chain_en` low (any of the three such combinations), `count` keeps its value across the edge.
- R7: Counting wraps. Up goes from all ones (255) to 0, and down goes from 0 to all ones (255).
- R8: `term` is 1 when `chain_en`=1 and either `up`=1 with `count` all ones, or `up`=0 with `count`=0. Otherwise it is 0, including at mid-range values.
- R9: `term` is 0 whenever `chain_en` is 0, at every count value and in both directions.
- R10: A change on `up` changes `term` within the same cycle, with no clock edge. It changes `count` only at the next rising edge.
- R11: After `clr_n` returns high, the first enabled rising edge steps from 0. For example, one up-count after release gives 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every operation except clear happens on its rising edge |
| clr_n | input | 1 | Asynchronous clear, active low, highest priority |
| load | input | 1 | Synchronous parallel preset request |
| preset | input | WIDTH | Value written into the count when `load` is high |
| cnt_en | input | 1 | Count enable |
| chain_en | input | 1 | Chain enable; also gates `term` |
| up | input | 1 | Direction select: 1 counts up, 0 counts down |
| count | output | WIDTH | Current count value |
| term | output | 1 | Combinational terminal-count flag used for chaining |

## Verification
Counting is run as runs of several edges up and then down from a loaded mid-range value, so a fault in step size or sign shows up in the result. Wrap is tested with loads of 255 and 0 followed by a single step in each direction. The three enable combinations that should inhibit counting are each applied on their own, which shows whether each enable gates the count. The flag is swept over all ones, zero and a mid value, with both directions and both chain-enable levels; the `up` input is also toggled between edges to separate its combinational effect on `term` from its registered effect on `count`.

// File: rtl/updn_pkg.sv
package updn_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_LOAD = 2'd1,
    OP_INC  = 2'd2,
    OP_DEC  = 2'd3
  } step_op_e;
endpackage

// File: rtl/updn_ctrl.sv
module updn_ctrl
  import updn_pkg::*;
(
  input  logic     load,
  input  logic     cnt_en,
  input  logic     chain_en,
  input  logic     up,
  output step_op_e op
);
  logic run;
  assign run = cnt_en & chain_en;

  always_comb begin
    if (load)     op = OP_LOAD;
    else if (run) op = up ? OP_INC : OP_DEC;
    else          op = OP_HOLD;
  end
endmodule

// File: rtl/updn_step.sv
module updn_step
  import updn_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  step_op_e         op,
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] preset,
  output logic [WIDTH-1:0] nxt
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  always_comb begin
    unique case (op)
      OP_LOAD: nxt = preset;
      OP_INC:  nxt = cur + ONE;
      OP_DEC:  nxt = cur - ONE;
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/updn_tc.sv
module updn_tc #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] cur,
  input  logic             up,
  input  logic             chain_en,
  output logic             term
);
  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] BOT = '0;

  logic at_end;
  assign at_end = up ? (cur == TOP) : (cur == BOT);
  assign term   = chain_en & at_end;
endmodule

// File: rtl/updn_counter.sv
module updn_counter
  import updn_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             load,
  input  logic [WIDTH-1:0] preset,
  input  logic             cnt_en,
  input  logic             chain_en,
  input  logic             up,
  output logic [WIDTH-1:0] count,
  output logic             term
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  step_op_e         op;
  logic [WIDTH-1:0] nxt;
  logic             tc_raw;

  updn_ctrl u_ctrl (
    .load     (load),
    .cnt_en   (cnt_en),
    .chain_en (chain_en),
    .up       (up),
    .op       (op)
  );

  updn_step #(.WIDTH(WIDTH)) u_step (
    .op     (op),
    .cur    (count),
    .preset (preset),
    .nxt    (nxt)
  );

  updn_tc #(.WIDTH(WIDTH)) u_tc (
    .cur      (count),
    .up       (up),
    .chain_en (chain_en),
    .term     (tc_raw)
  );

  assign term = tc_raw;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) count <= '0;
    else        count <= nxt;
  end

  // R3
  load_wins_chk: assert property (@(posedge clk) disable iff (!clr_n)
    load |=> count == $past(preset));

  // R4
  step_up_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (!load && cnt_en && chain_en && up) |=> count == $past(count) + ONE);

  // R5
  step_down_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (!load && cnt_en && chain_en && !up) |=> count == $past(count) - ONE);

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (!load && !(cnt_en && chain_en)) |=> $stable(count));

  // R9
  always_comb begin
    gated_tc_chk: assert (chain_en || !term);
  end
endmodule

// File: tb/test_updn_counter.sv
`timescale 1ns/1ps
module test_updn_counter;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         clr_n = 1'b0;
  logic         load = 1'b0;
  logic [W-1:0] preset = '0;
  logic         cnt_en = 1'b0;
  logic         chain_en = 1'b0;
  logic         up = 1'b1;
  logic [W-1:0] count;
  logic         term;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  updn_counter #(.WIDTH(W)) i_updn_counter (
    .clk(clk), .clr_n(clr_n), .load(load), .preset(preset),
    .cnt_en(cnt_en), .chain_en(chain_en), .up(up),
    .count(count), .term(term)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive after falling edge, sample 1 ns after rising edge
  task automatic edge1();
    @(posedge clk);
    #1;
  endtask

  task automatic setin(input logic ld, input logic [W-1:0] p,
                       input logic ce, input logic te, input logic u);
    @(negedge clk);
    load = ld; preset = p; cnt_en = ce; chain_en = te; up = u;
  endtask

  task automatic do_load(input logic [W-1:0] v);
    setin(1'b1, v, 1'b0, 1'b0, 1'b1);
    edge1();
    chk("R3 load", count, v);
  endtask

  task automatic t_reset();
    #1;
    chk("R1 reset state", count, 0);
    setin(1'b1, 8'hA5, 1'b1, 1'b1, 1'b1);
    edge1(); edge1();
    chk("R2 clear dominates", count, 0);
    setin(1'b0, 8'h00, 1'b1, 1'b1, 1'b1);
    clr_n = 1'b1;
    edge1();
    chk("R11 resume from zero", count, 1);
  endtask

  task automatic t_load_priority();
    setin(1'b1, 8'h3C, 1'b1, 1'b1, 1'b1);
    edge1();
    chk("R3 load over count up", count, 8'h3C);
    setin(1'b1, 8'hC3, 1'b1, 1'b1, 1'b0);
    edge1();
    chk("R3 load over count down", count, 8'hC3);
  endtask

  task automatic t_count();
    do_load(8'd100);
    setin(1'b0, 8'h00, 1'b1, 1'b1, 1'b1);
    for (int i = 1; i <= 5; i++) begin
      edge1();
      chk("R4 up step", count, 100 + i);
    end
    setin(1'b0, 8'h00, 1'b1, 1'b1, 1'b0);
    for (int i = 1; i <= 7; i++) begin
      edge1();
      chk("R5 down step", count, 105 - i);
    end
  endtask

  task automatic t_hold();
    do_load(8'd50);
    setin(1'b0, 8'h00, 1'b0, 1'b1, 1'b1);
    edge1();
    chk("R6 hold cnt_en low", count, 50);
    setin(1'b0, 8'h00, 1'b1, 1'b0, 1'b1);
    edge1();
    chk("R6 hold chain_en low", count, 50);
    setin(1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
    edge1();
    chk("R6 hold both low", count, 50);
  endtask

  task automatic t_wrap();
    do_load(8'hFF);
    setin(1'b0, 8'h00, 1'b1, 1'b1, 1'b1);
    edge1();
    chk("R7 wrap up", count, 0);
    setin(1'b0, 8'h00, 1'b1, 1'b1, 1'b0);
    edge1();
    chk("R7 wrap down", count, 255);
  endtask

  task automatic t_term();
    do_load(8'hFF);
    setin(1'b0, 8'h00, 1'b0, 1'b1, 1'b1); #1;
    chk("R8 term up at all ones", term, 1);
    up = 1'b0; #1;
    chk("R8 term down at all ones", term, 0);
    chain_en = 1'b0; up = 1'b1; #1;
    chk("R9 term gated at all ones", term, 0);
    do_load(8'h00);
    setin(1'b0, 8'h00, 1'b0, 1'b1, 1'b0); #1;
    chk("R8 term down at zero", term, 1);
    up = 1'b1; #1;
    chk("R8 term up at zero", term, 0);
    chain_en = 1'b0; up = 1'b0; #1;
    chk("R9 term gated at zero", term, 0);
    do_load(8'd77);
    setin(1'b0, 8'h00, 1'b0, 1'b1, 1'b1); #1;
    chk("R8 term mid up", term, 0);
    up = 1'b0; #1;
    chk("R8 term mid down", term, 0);
  endtask

  task automatic t_dir_timing();
    do_load(8'h00);
    setin(1'b0, 8'h00, 1'b1, 1'b1, 1'b1); #1;
    chk("R10 term low before toggle", term, 0);
    up = 1'b0; #1;
    chk("R10 term follows up at once", term, 1);
    chk("R10 count unchanged before edge", count, 0);
    edge1();
    chk("R10 count steps down at edge", count, 255);
  endtask

  task automatic t_async_clear();
    do_load(8'd9);
    @(negedge clk);
    #0.5;
    clr_n = 1'b0;
    #0.5;
    chk("R1 async clear without edge", count, 0);
    setin(1'b0, 8'h00, 1'b1, 1'b1, 1'b1);
    edge1();
    chk("R2 count blocked while cleared", count, 0);
    @(negedge clk);
    clr_n = 1'b1;
    edge1();
    chk("R11 first step after release", count, 1);
  endtask

  initial begin
    t_reset();
    t_load_priority();
    t_count();
    t_hold();
    t_wrap();
    t_term();
    t_dir_timing();
    t_async_clear();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule